// File: doc/BRIEF.md
# System Control Register Bank

This block is a 32-bit register bank for board-level control, reached over a simple word-addressed bus with separate read and write strobes. It holds a fixed board identity word, eight user LED outputs, a flash write-protect output, and two flag words. It also shows three board inputs as read-only bits: card present, card write-protect and the master-site strap.

Neither flag word is written by plain overwrite. Each flag word has a set address and a clear address. A write to the set address ORs the written ones into the word. A write to the clear address clears every bit that is written as one. The ordinary flags, the LEDs and the flash control bit are cleared by either the power-on reset or the soft reset. The second flag word survives a soft reset and is cleared only by power-on reset, so it can carry state across a soft reboot.

The `addr` port carries a word index, which is the byte offset divided by four. Read data is registered.

Top module: `sysctl_regbank`

## Requirements
- R1: While `por_n` is low, and after it is released, `led_o` is 0, `flash_wp_n_o` is 0 (flash protected), `rdata` is 0, and both flag words read 0.
- R2: A read of byte offset 0x000 (index 0) returns parameter `BOARD_ID` in bits 27:16, with every other bit 0.
- R3: A write to byte offset 0x008 (index 2) loads `wdata[7:0]` onto `led_o` at the clock edge of the write. Bit 0 drives the first LED. A read of this offset returns that byte, with bits 31:8 at 0.
- R4: A write to byte offset 0x030 (index 12) ORs `wdata` into the flag word. A read of 0x030 returns the flag word.
- R5: A write to byte offset 0x034 (index 13) clears each flag bit whose `wdata` bit is 1. A read of 0x034 returns 0.
- R6: The persistent flag word reads at byte offset 0x038 (index 14). A write there ORs `wdata` into the word. A write to byte offset 0x03C (index 15) clears the bits written as 1.
- R7: A soft reset (`srst_n` low at a clock edge) clears the LEDs, the flash control bit and the flag word. The persistent flag word keeps its value.
- R8: A read of byte offset 0x048 (index 18) returns card present in bit 0 and card write-protect in bit 1. Each is sampled through one register. Writes to this offset have no effect.
- R9: A write to byte offset 0x04C (index 19) loads `wdata[0]` into the active-low `flash_wp_n_o` at the edge of the write. A read of this offset returns that bit in bit 0.
- R10: A read of byte offset 0x060 (index 24) returns the sampled master-site strap in bit 14, with every other bit 0. Writes to this offset have no effect.
- R11: A read of any unmapped index returns 0. A write to an unmapped index changes no register.
- R12: `rdata` takes the addressed value at the clock edge where `rd_en` is high. At any edge where `rd_en` is low, `rdata` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| srst_n | input | 1 | Synchronous soft reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Word index (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| card_present_i | input | 1 | Card inserted |
| card_wp_i | input | 1 | Card write-protect switch |
| master_strap_i | input | 1 | Master-site strap |
| led_o | output | LED_N | User LED drives |
| flash_wp_n_o | output | 1 | Flash write-protect, active low |

## Verification
Results fall due at fixed cycle counts:
- Read data appears one edge after the `rd_en` cycle.
- The LED and flash pins change at the edge of the write itself.
- A board-input change can be seen by a read issued after one sampling edge.

The driver raises a strobe for exactly one cycle, between two falling edges. It pushes the expected read word into a queue at the same time. A monitor registers `rd_en` itself and, on the falling edge after the capturing edge, pops and compares the word. Pin checks are sampled on that same falling edge after the write. Input changes are given two edges before the read that depends on them.

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
  parameter int          AW       = 10,
  parameter int          LED_N    = 8,
  parameter int          ID_W     = 12,
  parameter logic [11:0] BOARD_ID = 12'h2A7
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             srst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             card_present_i,
  input  logic             card_wp_i,
  input  logic             master_strap_i,
  output logic [LED_N-1:0] led_o,
  output logic             flash_wp_n_o
);
  localparam logic [AW-1:0] IX_ID    = AW'(0);
  localparam logic [AW-1:0] IX_LED   = AW'(2);
  localparam logic [AW-1:0] IX_FSET  = AW'(12);
  localparam logic [AW-1:0] IX_FCLR  = AW'(13);
  localparam logic [AW-1:0] IX_PSET  = AW'(14);
  localparam logic [AW-1:0] IX_PCLR  = AW'(15);
  localparam logic [AW-1:0] IX_CARD  = AW'(18);
  localparam logic [AW-1:0] IX_FLASH = AW'(19);
  localparam logic [AW-1:0] IX_MISC  = AW'(24);
  localparam int ID_LSB    = 16;
  localparam int STRAP_BIT = 14;

  logic [LED_N-1:0] led_q;
  logic             flash_q;
  logic [31:0]      flags_q;
  logic [31:0]      pflags_q;
  logic [1:0]       card_q;
  logic             strap_q;
  logic [31:0]      rd_mux;

  always_comb begin
    rd_mux = '0;
    case (addr)
      IX_ID:    rd_mux = 32'(BOARD_ID[ID_W-1:0]) << ID_LSB;
      IX_LED:   rd_mux = 32'(led_q);
      IX_FSET:  rd_mux = flags_q;
      IX_PSET:  rd_mux = pflags_q;
      IX_CARD:  rd_mux = 32'(card_q);
      IX_FLASH: rd_mux = 32'(flash_q);
      IX_MISC:  rd_mux = 32'(strap_q) << STRAP_BIT;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      led_q    <= '0;
      flash_q  <= 1'b0;
      flags_q  <= '0;
      pflags_q <= '0;
      card_q   <= '0;
      strap_q  <= 1'b0;
      rdata    <= '0;
    end else begin
      card_q  <= {card_wp_i, card_present_i};
      strap_q <= master_strap_i;
      rdata   <= rd_en ? rd_mux : '0;
      if (wr_en && addr == IX_PSET)      pflags_q <= pflags_q | wdata;
      else if (wr_en && addr == IX_PCLR) pflags_q <= pflags_q & ~wdata;
      if (!srst_n) begin
        led_q   <= '0;
        flash_q <= 1'b0;
        flags_q <= '0;
      end else if (wr_en) begin
        case (addr)
          IX_LED:   led_q   <= wdata[LED_N-1:0];
          IX_FLASH: flash_q <= wdata[0];
          IX_FSET:  flags_q <= flags_q | wdata;
          IX_FCLR:  flags_q <= flags_q & ~wdata;
          default:  ;
        endcase
      end
    end
  end

  assign led_o        = led_q;
  assign flash_wp_n_o = flash_q;
endmodule

module sysctl_regbank_chk #(
  parameter int AW    = 10,
  parameter int LED_N = 8
) (
  input logic             clk,
  input logic             por_n,
  input logic             srst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [AW-1:0]    addr,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic [LED_N-1:0] led_o,
  input logic             flash_wp_n_o,
  input logic [31:0]      flags_q,
  input logic [31:0]      pflags_q
);
  a_r3_led_load: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && srst_n && addr == AW'(2)) |=> led_o == $past(wdata[LED_N-1:0]));
  a_r4_flag_set: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && srst_n && addr == AW'(12)) |=> (flags_q & $past(wdata)) == $past(wdata));
  a_r5_flag_clr: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && srst_n && addr == AW'(13)) |=> (flags_q & $past(wdata)) == 32'h0);
  a_r6_pflag_set: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && addr == AW'(14)) |=> (pflags_q & $past(wdata)) == $past(wdata));
  a_r7_pflag_keep: assert property (@(posedge clk) disable iff (!por_n)
    (!srst_n && !wr_en) |=> $stable(pflags_q));
  a_r7_soft_clear: assert property (@(posedge clk) disable iff (!por_n)
    !srst_n |=> (led_o == '0 && !flash_wp_n_o && flags_q == 32'h0));
  a_r9_flash_load: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && srst_n && addr == AW'(19)) |=> flash_wp_n_o == $past(wdata[0]));
  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!por_n)
    !rd_en |=> rdata == 32'h0);
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.AW(AW), .LED_N(LED_N)) u_chk (
  .clk(clk), .por_n(por_n), .srst_n(srst_n), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .led_o(led_o),
  .flash_wp_n_o(flash_wp_n_o), .flags_q(flags_q), .pflags_q(pflags_q)
);

// File: tb/sim_sysctl_regbank.sv
`timescale 1ns/100ps
module sim_sysctl_regbank;
  localparam int AW = 10;
  localparam int LED_N = 8;
  localparam logic [11:0] BID = 12'h2A7;

  logic clk = 1'b0;
  logic por_n = 1'b0, srst_n = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic card_present_i = 1'b0, card_wp_i = 1'b0, master_strap_i = 1'b0;
  logic [LED_N-1:0] led_o;
  logic flash_wp_n_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  sysctl_regbank #(.AW(AW), .LED_N(LED_N), .BOARD_ID(BID)) u0 (
    .clk(clk), .por_n(por_n), .srst_n(srst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .card_present_i(card_present_i), .card_wp_i(card_wp_i),
    .master_strap_i(master_strap_i), .led_o(led_o), .flash_wp_n_o(flash_wp_n_o));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R12 unexpected read", rdata, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(int a, logic [31:0] d);
    addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string req);
    addr = AW'(a); rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 led in reset", 32'(led_o), 32'h0);
    check("R1 flash in reset", 32'(flash_wp_n_o), 32'h0);
    check("R1 rdata in reset", rdata, 32'h0);
    por_n = 1'b1;
    @(negedge clk);
    rd(12, 32'h0, "R1 flags after reset");
    rd(14, 32'h0, "R1 persistent flags after reset");
    rd(0, 32'(BID) << 16, "R2 identity");
    @(negedge clk);
    check("R12 rdata idle zero", rdata, 32'h0);

    wr(2, 32'hFFFF_FFA5);
    check("R3 led pins", 32'(led_o), 32'hA5);
    rd(2, 32'hA5, "R3 led readback");
    wr(2, 32'h0000_0001);
    check("R3 first led only", 32'(led_o), 32'h01);

    wr(12, 32'h0000_00F0);
    wr(12, 32'h0000_0F00);
    rd(12, 32'h0000_0FF0, "R4 flags or");
    wr(13, 32'h0000_0330);
    rd(12, 32'h0000_0CC0, "R5 flags clear");
    rd(13, 32'h0, "R5 clear address reads zero");

    wr(14, 32'h8000_0001);
    wr(15, 32'h0000_0001);
    rd(14, 32'h8000_0000, "R6 persistent set/clear");

    card_present_i = 1'b1;
    repeat (2) @(negedge clk);
    rd(18, 32'h1, "R8 card present");
    card_wp_i = 1'b1;
    repeat (2) @(negedge clk);
    rd(18, 32'h3, "R8 card present and wp");
    wr(18, 32'h0);
    rd(18, 32'h3, "R8 write ignored");

    wr(19, 32'h1);
    check("R9 flash enable pin", 32'(flash_wp_n_o), 32'h1);
    rd(19, 32'h1, "R9 flash readback");
    wr(19, 32'hFFFF_FFFE);
    check("R9 flash protect pin", 32'(flash_wp_n_o), 32'h0);

    master_strap_i = 1'b1;
    repeat (2) @(negedge clk);
    rd(24, 32'h0000_4000, "R10 master strap");
    wr(24, 32'h0);
    rd(24, 32'h0000_4000, "R10 write ignored");

    rd(5, 32'h0, "R11 unmapped read");
    wr(5, 32'hFFFF_FFFF);
    rd(5, 32'h0, "R11 unmapped write");
    rd(2, 32'h01, "R11 led untouched");
    rd(12, 32'h0000_0CC0, "R11 flags untouched");

    wr(19, 32'h1);
    srst_n = 1'b0;
    @(negedge clk);
    srst_n = 1'b1;
    check("R7 led cleared", 32'(led_o), 32'h0);
    check("R7 flash cleared", 32'(flash_wp_n_o), 32'h0);
    rd(12, 32'h0, "R7 flags cleared");
    rd(14, 32'h8000_0000, "R7 persistent kept");

    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    rd(14, 32'h0, "R1 persistent cleared by power-on");
    repeat (3) @(negedge clk);
    check("R12 scoreboard drained", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule